// File: doc/BRIEF.md
# Vector Lane Widening Left Shifter

This block takes a 128-bit source vector and works on one 64-bit half of it, picked by a half-select input. It splits that half into lanes of 8, 16 or 32 bits. Each lane is extended to twice its width, with zeros or with copies of its sign bit, and is then shifted left. The widened lanes together form a 128-bit result.

Two immediate fields control the operation: a 4-bit high field and a 3-bit low field. The highest set bit of the high field selects the lane size. The shift amount is the 7-bit value `{high, low}` minus the lane width. An encoding that names a 64-bit lane, or that has no bit set in the high field, is illegal.

The block takes one operation per cycle and gives its result one cycle later. On an accepted request it latches the whole selected half and the decoded controls. All result lanes are then built from that copy, so a caller can write the result back over the source register without corrupting lanes that have not been read yet.

Top module: `simd_widen_shl`

## Requirements
- R1: When the high immediate field has bit 3 set (64-bit lane) or is all zeros, `illegal` is 1 and `result` is all zeros while `out_valid` is 1.
- R2: The lane size comes from the highest set bit of the high field: bit 0 selects 8 bits, bit 1 selects 16 bits and bit 2 selects 32 bits. Lower bits that are also set do not change the choice.
- R3: With `upper_sel` = 1 the lanes come from source bits 127:64. With `upper_sel` = 0 they come from bits 63:0.
- R4: With `is_signed` = 0 each lane is zero-extended before the shift.
- R5: With `is_signed` = 1 each lane is sign-extended before the shift.
- R6: The left shift amount is `{imm_hi, imm_lo}` minus the lane width, which is 0 to width-1. An amount of 0 gives a pure widening.
- R7: Result lane i has twice the source lane width. It sits at bits `[i*2W +: 2W]` and comes from source lane i at bits `[i*W +: W]` of the selected half.
- R8: `out_valid` goes high on the clock edge that follows an edge where `in_valid` was high, and low otherwise.
- R9: The result is built only from the values latched with the request. Source or control changes while `in_valid` is low do not change `result`.
- R10: After reset, `out_valid`, `illegal` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; latches source and controls |
| src_vec | input | 128 | Source vector |
| imm_hi | input | 4 | High immediate field (lane size and shift) |
| imm_lo | input | 3 | Low immediate field (shift) |
| is_signed | input | 1 | 1 = sign-extend lanes, 0 = zero-extend |
| upper_sel | input | 1 | 1 = use bits 127:64, 0 = use bits 63:0 |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 128 | Widened, shifted lanes |
| illegal | output | 1 | Request used a reserved lane size encoding |

## Verification
The hardest case to reach from the ports is the overlapping-destination case. The result must be unaffected when the source changes after the request has been accepted. The bench creates this case by issuing a request and then, in the very next cycle, putting a different source vector and different controls on the inputs with `in_valid` low. It then checks that the result still matches the original request. The shift boundaries also matter: zero shift and a shift of width-1 with a negative lane. These drive sign bits into the top bit of each wide lane, so the bench pairs them with lane patterns whose top bits differ from lane to lane.

// File: rtl/wsh_pkg.sv
package wsh_pkg;
   // Lane size chosen by the decoder; the order matches the high-field bit index.
   typedef enum logic [1:0] {
      SZ_8       = 2'd0,
      SZ_16      = 2'd1,
      SZ_32      = 2'd2,
      SZ_ILLEGAL = 2'd3
   } wsh_size_e;

   localparam int unsigned NUM_SIZES = 3;
endpackage

// File: rtl/wsh_decode.sv
module wsh_decode
   import wsh_pkg::*;
#(
   parameter int unsigned IMM_HI_W = 4,
   parameter int unsigned IMM_LO_W = 3,
   localparam int unsigned SH_W   = IMM_HI_W + IMM_LO_W,
   localparam int unsigned BASE_W = 1 << IMM_LO_W,
   localparam int unsigned IDX_W  = $clog2(IMM_HI_W)
) (
   input  logic [IMM_HI_W-1:0] imm_hi,
   input  logic [IMM_LO_W-1:0] imm_lo,
   output wsh_size_e           size,
   output logic [SH_W-1:0]     shamt
);
   logic [IDX_W-1:0] msb_idx;
   logic             any_set;
   logic [SH_W-1:0]  imm_all;
   logic [SH_W-1:0]  lane_w;

   assign imm_all = {imm_hi, imm_lo};

   // Highest set bit of the high field; later iterations override earlier ones.
   always_comb begin
      msb_idx = '0;
      any_set = 1'b0;
      for (int k = 0; k < IMM_HI_W; k++) begin
         if (imm_hi[k]) begin
            msb_idx = IDX_W'(k);
            any_set = 1'b1;
         end
      end
   end

   always_comb begin
      lane_w = SH_W'(BASE_W) << msb_idx;
      if (any_set && (int'(msb_idx) < int'(NUM_SIZES))) begin
         size  = wsh_size_e'(msb_idx);
         shamt = imm_all - lane_w;
      end else begin
         size  = SZ_ILLEGAL;
         shamt = '0;
      end
   end
endmodule

// File: rtl/wsh_lane.sv
module wsh_lane #(
   parameter int unsigned SRC_W = 8,
   parameter int unsigned SH_W  = 7
) (
   input  logic [SRC_W-1:0]   src,
   input  logic               sgn,
   input  logic [SH_W-1:0]    shamt,
   output logic [2*SRC_W-1:0] dst
);
   logic [2*SRC_W-1:0] ext;

   assign ext = {{SRC_W{sgn & src[SRC_W-1]}}, src};
   assign dst = ext << shamt;
endmodule

// File: rtl/wsh_lane_group.sv
module wsh_lane_group #(
   parameter int unsigned HALF_W = 64,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned SH_W   = 7,
   localparam int unsigned N_LANES = HALF_W / LANE_W
) (
   input  logic [HALF_W-1:0]   half,
   input  logic                sgn,
   input  logic [SH_W-1:0]     shamt,
   output logic [2*HALF_W-1:0] wide
);
   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      wsh_lane #(
         .SRC_W (LANE_W),
         .SH_W  (SH_W)
      ) u_lane (
         .src   (half[i*LANE_W +: LANE_W]),
         .sgn   (sgn),
         .shamt (shamt),
         .dst   (wide[i*2*LANE_W +: 2*LANE_W])
      );
   end
endmodule

// File: rtl/simd_widen_shl.sv
module simd_widen_shl
   import wsh_pkg::*;
#(
   parameter int unsigned HALF_W   = 64,
   parameter int unsigned IMM_HI_W = 4,
   parameter int unsigned IMM_LO_W = 3,
   localparam int unsigned VEC_W  = 2 * HALF_W,
   localparam int unsigned SH_W   = IMM_HI_W + IMM_LO_W,
   localparam int unsigned BASE_W = 1 << IMM_LO_W,
   localparam int unsigned MAX_LW = BASE_W << (NUM_SIZES - 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [VEC_W-1:0]    src_vec,
   input  logic [IMM_HI_W-1:0] imm_hi,
   input  logic [IMM_LO_W-1:0] imm_lo,
   input  logic                is_signed,
   input  logic                upper_sel,
   output logic                out_valid,
   output logic [VEC_W-1:0]    result,
   output logic                illegal
);
   // Elaboration checks on the parameter set.
   if (IMM_HI_W != NUM_SIZES + 1) begin : g_bad_hi
      $error("simd_widen_shl: IMM_HI_W must equal one more than the number of lane sizes");
   end
   if ((HALF_W % MAX_LW) != 0 || HALF_W < MAX_LW) begin : g_bad_half
      $error("simd_widen_shl: HALF_W must be a multiple of the widest lane");
   end

   wsh_size_e         dec_size;
   logic [SH_W-1:0]   dec_shamt;

   wsh_decode #(
      .IMM_HI_W (IMM_HI_W),
      .IMM_LO_W (IMM_LO_W)
   ) u_dec (
      .imm_hi (imm_hi),
      .imm_lo (imm_lo),
      .size   (dec_size),
      .shamt  (dec_shamt)
   );

   // Captured operation: the whole selected half is held so that every
   // result lane is derived from the same snapshot.
   logic [HALF_W-1:0] half_q;
   logic              sgn_q;
   logic [SH_W-1:0]   shamt_q;
   wsh_size_e         size_q;
   logic              valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q  <= '0;
         sgn_q   <= 1'b0;
         shamt_q <= '0;
         size_q  <= SZ_ILLEGAL;
         valid_q <= 1'b0;
      end else begin
         valid_q <= in_valid;
         if (in_valid) begin
            half_q  <= upper_sel ? src_vec[VEC_W-1:HALF_W] : src_vec[HALF_W-1:0];
            sgn_q   <= is_signed;
            shamt_q <= dec_shamt;
            size_q  <= dec_size;
         end
      end
   end

   logic [VEC_W-1:0] cand [NUM_SIZES];

   for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
      wsh_lane_group #(
         .HALF_W (HALF_W),
         .LANE_W (BASE_W << k),
         .SH_W   (SH_W)
      ) u_grp (
         .half  (half_q),
         .sgn   (sgn_q),
         .shamt (shamt_q),
         .wide  (cand[k])
      );
   end

   always_comb begin
      unique case (size_q)
         SZ_8:    result = cand[0];
         SZ_16:   result = cand[1];
         SZ_32:   result = cand[2];
         default: result = '0;
      endcase
   end

   assign out_valid = valid_q;
   assign illegal   = valid_q & (size_q == SZ_ILLEGAL);
endmodule

// File: rtl/wsh_checker.sv
module wsh_checker #(
   parameter int unsigned HALF_W   = 64,
   parameter int unsigned IMM_HI_W = 4,
   parameter int unsigned IMM_LO_W = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic [IMM_HI_W-1:0] imm_hi,
   input logic                out_valid,
   input logic [2*HALF_W-1:0] result,
   input logic                illegal
);
   logic bad_enc;
   assign bad_enc = imm_hi[IMM_HI_W-1] | (imm_hi == '0);

   assert_illegal_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (out_valid && result == '0));

   assert_illegal_raise_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && bad_enc) |=> illegal);

   assert_legal_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !bad_enc) |=> !illegal);

   assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
endmodule

bind simd_widen_shl wsh_checker #(
   .HALF_W   (HALF_W),
   .IMM_HI_W (IMM_HI_W),
   .IMM_LO_W (IMM_LO_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .imm_hi    (imm_hi),
   .out_valid (out_valid),
   .result    (result),
   .illegal   (illegal)
);

// File: tb/sim_simd_widen_shl.sv
`timescale 1ns/1ps
module sim_simd_widen_shl;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] src_vec = '0;
   logic [3:0]   imm_hi = '0;
   logic [2:0]   imm_lo = '0;
   logic         is_signed = 1'b0;
   logic         upper_sel = 1'b0;
   logic         out_valid;
   logic [127:0] result;
   logic         illegal;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   simd_widen_shl u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .src_vec   (src_vec),
      .imm_hi    (imm_hi),
      .imm_lo    (imm_lo),
      .is_signed (is_signed),
      .upper_sel (upper_sel),
      .out_valid (out_valid),
      .result    (result),
      .illegal   (illegal)
   );

   localparam logic [127:0] PAT_A = 128'h89AB_CDEF_0123_4567_F0E1_D2C3_B4A5_9687;
   localparam logic [127:0] PAT_B = 128'h7F80_01FE_8000_7FFF_FFFF_0000_8001_7FFE;
   localparam logic [127:0] PAT_C = 128'hDEAD_BEEF_0BAD_F00D_1357_9BDF_2468_ACE0;

   // Independent model of the requirements.
   function automatic logic [127:0] model(logic [127:0] src, logic [3:0] hi, logic [2:0] lo,
                                          logic sgn, logic up);
      int es;
      int sh;
      logic [63:0]  half;
      logic [63:0]  m1;
      logic [63:0]  m2;
      logic [63:0]  lv;
      logic [127:0] r;
      if (hi[3] || hi == 4'd0) return '0;
      es   = hi[2] ? 32 : (hi[1] ? 16 : 8);
      sh   = int'({hi, lo}) - es;
      half = up ? src[127:64] : src[63:0];
      m1   = (64'd1 << es) - 64'd1;
      m2   = (es == 32) ? '1 : ((64'd1 << (2 * es)) - 64'd1);
      r    = '0;
      for (int i = 0; i < 64 / es; i++) begin
         lv = (half >> (i * es)) & m1;
         if (sgn && lv[es-1]) lv = lv | ~m1;
         lv = (lv << sh) & m2;
         r  = r | ({64'd0, lv} << (i * 2 * es));
      end
      return r;
   endfunction

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One request; outputs are checked at the next falling edge.
   task automatic t_op(string req, logic [127:0] src, logic [3:0] hi, logic [2:0] lo,
                       logic sgn, logic up);
      logic [127:0] exp;
      exp = model(src, hi, lo, sgn, up);
      @(negedge clk);
      src_vec = src; imm_hi = hi; imm_lo = lo; is_signed = sgn; upper_sel = up;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk({req, " R8 out_valid"}, {127'd0, out_valid}, 128'd1);
      chk({req, " R1 illegal"}, {127'd0, illegal},
          {127'd0, (hi[3] || hi == 4'd0)});
      chk({req, " result"}, result, exp);
   endtask

   task automatic t_reset;
      chk("R10 out_valid after reset", {127'd0, out_valid}, '0);
      chk("R10 illegal after reset", {127'd0, illegal}, '0);
      chk("R10 result after reset", result, '0);
   endtask

   // Source overwritten right after capture (R9).
   task automatic t_overlap;
      logic [127:0] exp;
      exp = model(PAT_A, 4'b0010, 3'b101, 1'b1, 1'b1);
      @(negedge clk);
      src_vec = PAT_A; imm_hi = 4'b0010; imm_lo = 3'b101; is_signed = 1'b1; upper_sel = 1'b1;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R9 overlap first cycle", result, exp);
      src_vec = PAT_C; imm_hi = 4'b0001; imm_lo = 3'b000; is_signed = 1'b0; upper_sel = 1'b0;
      @(negedge clk);
      chk("R9 result held after source change", result, exp);
      chk("R8 out_valid low without request", {127'd0, out_valid}, '0);
   endtask

   // Two requests on consecutive cycles (R8, R2).
   task automatic t_back_to_back;
      logic [127:0] e1;
      logic [127:0] e2;
      e1 = model(PAT_B, 4'b0001, 3'b010, 1'b1, 1'b0);
      e2 = model(PAT_B, 4'b0110, 3'b001, 1'b0, 1'b1);
      @(negedge clk);
      src_vec = PAT_B; imm_hi = 4'b0001; imm_lo = 3'b010; is_signed = 1'b1; upper_sel = 1'b0;
      in_valid = 1'b1;
      @(negedge clk);
      chk("R8 back-to-back first result", result, e1);
      imm_hi = 4'b0110; imm_lo = 3'b001; is_signed = 1'b0; upper_sel = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 back-to-back second valid", {127'd0, out_valid}, 128'd1);
      chk("R2 back-to-back second result", result, e2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_op("R4 R6 8b unsigned low shift0", PAT_A, 4'b0001, 3'b000, 1'b0, 1'b0);
      t_op("R5 R3 8b signed high shift3", PAT_A, 4'b0001, 3'b011, 1'b1, 1'b1);
      t_op("R5 R6 8b signed low shift7", PAT_B, 4'b0001, 3'b111, 1'b1, 1'b0);
      t_op("R2 R6 16b signed low shift15", PAT_B, 4'b0011, 3'b111, 1'b1, 1'b0);
      t_op("R4 R3 16b unsigned high shift4", PAT_C, 4'b0010, 3'b100, 1'b0, 1'b1);
      t_op("R7 R6 32b unsigned high shift31", PAT_A, 4'b0111, 3'b111, 1'b0, 1'b1);
      t_op("R5 R7 32b signed low shift0", PAT_B, 4'b0100, 3'b000, 1'b1, 1'b0);
      t_op("R7 R3 8b unsigned high lanes", PAT_C, 4'b0001, 3'b001, 1'b0, 1'b1);
      t_op("R1 64b lane encoding", PAT_A, 4'b1010, 3'b110, 1'b1, 1'b0);
      t_op("R1 empty high field", PAT_A, 4'b0000, 3'b111, 1'b0, 1'b1);
      t_overlap();
      t_back_to_back();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R8 actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule